// File: doc/BRIEF.md
# Voting Asynchronous Serial Receiver

This block turns one asynchronous serial line into parallel characters. A 16-bit divisor applied to the system clock produces an oversampling tick at sixteen ticks per bit time, so no second clock is needed. Each bit is decided by a two-of-three vote over samples taken at ticks 7, 8 and 9 of its bit time. A falling edge opens a start bit, and that start bit must still read low at tick 8. Otherwise the edge is treated as noise and the receiver returns to idle.

The character length can be 5 to 8 data bits, received least significant bit first. A parity bit is optional, and it can be checked as even or odd. A finished character lands in a one-entry holding register with a data-ready flag, so the next character can shift in while software reads the last one. Parity, framing, break and overrun conditions are reported beside the held byte. After a low stop bit, the receiver waits for the line to return high before it accepts a new start edge.

Top module: `uart_vote_rx`

## Requirements
- R1: `char_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. Unused upper bits of `rx_data` read zero.
- R2: With `parity_en` high, one parity bit follows the data bits. `parity_odd` set to 0 means even parity and 1 means odd parity. `err_parity` is set when the total count of ones over the data and parity bits is wrong for the selected mode. With `parity_en` low, no parity bit is expected and `err_parity` stays low.
- R3: Each data, parity and stop bit takes the majority of three line samples at oversampling ticks 7, 8 and 9 of its 16-tick bit time. A disturbance seen by only one of those samples does not change the received value.
- R4: After a falling edge, if the line reads high at tick 8 of the start bit, no character is produced and the receiver waits for the next falling edge.
- R5: When the stop bit votes low, `err_framing` is set with the character. No new start is accepted until the line has been seen high again.
- R6: When every voted bit of a frame is low (data, parity if enabled, and stop), the character is reported as a break. `err_break` is 1, `err_framing` is 1 and `rx_data` is 0.
- R7: A completed character loads `rx_data` and its error flags and sets `data_ready`. A one-cycle `rd_strobe` clears `data_ready`.
- R8: If a character completes while `data_ready` is set and no read occurs in that cycle, the held character and its flags are kept and `err_overrun` is set. A read clears `err_overrun`.
- R9: The oversampling tick fires once every `divisor` clock cycles. A divisor of 0 or 1 gives a tick every clock.
- R10: After reset, `data_ready`, all error flags and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| divisor | input | 16 | Clocks per oversampling tick |
| char_len | input | 2 | Data length select (5 to 8 bits) |
| parity_en | input | 1 | Expect a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Held character, right aligned |
| data_ready | output | 1 | Holding register contains an unread character |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_framing | output | 1 | Stop bit of the held character voted low |
| err_break | output | 1 | Held character was a break |
| err_overrun | output | 1 | A character was lost because the register was full |

## Verification
The assertions assume that `divisor`, `char_len`, `parity_en` and `parity_odd` stay constant while a frame is being received. They also assume `rd_strobe` is a single-cycle pulse. The bench changes configuration only while the line is idle and issues each read as one pulse between two falling clock edges. Serial frames are driven at exactly sixteen times the divisor, in clocks per bit. The only disturbances are a short glitch at a bit centre and a start pulse shorter than half a bit, so every vote window sees a stable line except at the glitches that were placed on purpose.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W        = $clog2(TICKS_PER_BIT);
  localparam logic [TICK_W-1:0] VOTE_A = TICK_W'(7);
  localparam logic [TICK_W-1:0] VOTE_B = TICK_W'(8);
  localparam logic [TICK_W-1:0] VOTE_C = TICK_W'(9);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       frm_err;
    logic       brk;
  } rx_char_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_d;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (divisor <= DIV_W'(1)) ? '0 : divisor - DIV_W'(1);
    if (cnt_q >= limit) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else if (g == 0) stage_q[g] <= line_in;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign line_out = stage_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_vote_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  output logic       char_done,
  output rx_char_t   char_out
);
  rx_state_e         state_q, state_d;
  logic [TICK_W-1:0] sc_q, sc_d;
  logic [2:0]        idx_q, idx_d;
  logic [1:0]        vote_q, vote_d;
  logic [7:0]        data_q, data_d;
  logic              pbit_q, pbit_d;
  logic              low_q, low_d;
  logic              done_d;
  rx_char_t          out_d;
  logic              maj;
  logic [2:0]        last_idx;

  assign maj      = (vote_q[0] & vote_q[1]) | (vote_q[0] & line) | (vote_q[1] & line);
  assign last_idx = {1'b0, char_len} + 3'd4;

  always_comb begin
    state_d = state_q;
    sc_d    = sc_q;
    idx_d   = idx_q;
    vote_d  = vote_q;
    data_d  = data_q;
    pbit_d  = pbit_q;
    low_d   = low_q;
    done_d  = 1'b0;
    out_d   = char_out;
    if (tick) begin
      sc_d = sc_q + TICK_W'(1);
      if (sc_q == VOTE_A) vote_d[0] = line;
      if (sc_q == VOTE_B) vote_d[1] = line;
      unique case (state_q)
        RX_IDLE: begin
          sc_d = '0;
          if (!line) begin
            state_d = RX_START;
            data_d  = '0;
            low_d   = 1'b1;
            pbit_d  = 1'b0;
          end
        end
        RX_START: begin
          if (sc_q == VOTE_B && line) begin
            state_d = RX_IDLE;
            sc_d    = '0;
          end else if (sc_q == LAST_TICK) begin
            state_d = RX_DATA;
            idx_d   = '0;
          end
        end
        RX_DATA: begin
          if (sc_q == VOTE_C) begin
            data_d[idx_q] = maj;
            low_d         = low_q & ~maj;
          end
          if (sc_q == LAST_TICK) begin
            if (idx_q == last_idx) state_d = parity_en ? RX_PARITY : RX_STOP;
            else idx_d = idx_q + 3'd1;
          end
        end
        RX_PARITY: begin
          if (sc_q == VOTE_C) begin
            pbit_d = maj;
            low_d  = low_q & ~maj;
          end
          if (sc_q == LAST_TICK) state_d = RX_STOP;
        end
        RX_STOP: begin
          if (sc_q == VOTE_C) begin
            done_d        = 1'b1;
            out_d.data    = data_q;
            out_d.frm_err = ~maj;
            out_d.brk     = low_q & ~maj;
            out_d.par_err = parity_en & ((^data_q ^ pbit_q) != parity_odd);
            state_d       = maj ? RX_IDLE : RX_WAIT_HIGH;
            sc_d          = '0;
          end
        end
        RX_WAIT_HIGH: begin
          sc_d = '0;
          if (line) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      sc_q      <= '0;
      idx_q     <= '0;
      vote_q    <= '0;
      data_q    <= '0;
      pbit_q    <= 1'b0;
      low_q     <= 1'b0;
      char_done <= 1'b0;
      char_out  <= '0;
    end else begin
      state_q   <= state_d;
      sc_q      <= sc_d;
      idx_q     <= idx_d;
      vote_q    <= vote_d;
      data_q    <= data_d;
      pbit_q    <= pbit_d;
      low_q     <= low_d;
      char_done <= done_d;
      char_out  <= out_d;
    end
  end

  assert_false_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && sc_q == VOTE_B && line) |=> (state_q == RX_IDLE && !char_done));
  assert_wait_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAIT_HIGH && !line) |=> (state_q == RX_WAIT_HIGH));
  assert_break_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && char_out.brk) |-> (char_out.frm_err && char_out.data == 8'd0));
  assert_no_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !parity_en && $stable(parity_en)) |-> !char_out.par_err);
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import uart_vote_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rx_char_t load_char,
  input  logic     rd_strobe,
  output rx_char_t held,
  output logic     ready,
  output logic     overrun
);
  rx_char_t held_d;
  logic     ready_d, overrun_d;

  always_comb begin
    held_d    = held;
    ready_d   = ready;
    overrun_d = overrun;
    if (rd_strobe) begin
      ready_d   = 1'b0;
      overrun_d = 1'b0;
    end
    if (load) begin
      if (ready && !rd_strobe) begin
        overrun_d = 1'b1;
      end else begin
        held_d  = load_char;
        ready_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      held    <= held_d;
      ready   <= ready_d;
      overrun <= overrun_d;
    end
  end

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> (!ready && !overrun));
  assert_load_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ready);
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load && !rd_strobe) |=> (overrun && held == $past(held)));
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uart_vote_rx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             rd_strobe,
  output logic [7:0]       rx_data,
  output logic             data_ready,
  output logic             err_parity,
  output logic             err_framing,
  output logic             err_break,
  output logic             err_overrun
);
  logic     tick, line_s, char_done;
  rx_char_t new_char, held;
  logic [3:0] nbits;

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rxd), .line_out(line_s));

  rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .char_done(char_done), .char_out(new_char));

  rx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .load(char_done), .load_char(new_char),
    .rd_strobe(rd_strobe), .held(held), .ready(data_ready), .overrun(err_overrun));

  assign rx_data     = held.data;
  assign err_parity  = held.par_err;
  assign err_framing = held.frm_err;
  assign err_break   = held.brk;
  assign nbits       = {2'b00, char_len} + 4'd5;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && $stable(char_len)) |-> ((rx_data >> nbits) == 8'd0));
  assert_overrun_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> data_ready);
endmodule

// File: tb/test_uart_vote_rx.sv
module test_uart_vote_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] divisor = 16'd2;
  logic [1:0]  char_len = 2'd3;
  logic        parity_en = 1'b0;
  logic        parity_odd = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [7:0]  rx_data;
  logic        data_ready, err_parity, err_framing, err_break, err_overrun;

  int checks = 0;
  int errors = 0;
  int bp = 32;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_vote_rx i_uart_vote_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor), .char_len(char_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .data_ready(data_ready), .err_parity(err_parity),
    .err_framing(err_framing), .err_break(err_break), .err_overrun(err_overrun));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  // glitch_bit >= 0 flips the line for two clocks at the centre of that data bit
  task automatic send(input logic [7:0] b, input int nlen, input bit pen, input bit podd,
                      input bit bad_par, input bit stop_v, input int glitch_bit);
    logic pb;
    pb = (^(b & 8'((1 << nlen) - 1))) ^ podd ^ bad_par;
    @(negedge clk);
    rxd = 1'b0; wait_clk(bp);
    for (int i = 0; i < nlen; i++) begin
      rxd = b[i];
      if (i == glitch_bit) begin
        wait_clk(bp/2); rxd = ~b[i]; wait_clk(2); rxd = b[i]; wait_clk(bp - bp/2 - 2);
      end else wait_clk(bp);
    end
    if (pen) begin rxd = pb; wait_clk(bp); end
    rxd = stop_v; wait_clk(bp);
    rxd = 1'b1; wait_clk(bp);
  endtask

  task automatic expect_char(input logic [7:0] exp, input bit pe, input bit fe, input bit bi,
                             input string tag);
    chk(data_ready === 1'b1, {tag, " ready"}, data_ready, 1);
    chk(rx_data === exp, {tag, " data"}, rx_data, exp);
    chk(err_parity === pe, {tag, " parity"}, err_parity, pe);
    chk(err_framing === fe, {tag, " framing"}, err_framing, fe);
    chk(err_break === bi, {tag, " break"}, err_break, bi);
    do_read();
    chk(data_ready === 1'b0, "R7 cleared by read", data_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [6];
    logic [7:0] m;
    int nlen;
    vals = '{8'h00, 8'hFF, 8'h55, 8'hA3, 8'h3C, 8'h81};
    wait_clk(3);
    // R10 reset state
    chk(data_ready === 0 && err_parity === 0 && err_framing === 0 && err_break === 0
        && err_overrun === 0, "R10 flags after reset", data_ready, 0);
    chk(rx_data === 8'h00, "R10 data after reset", rx_data, 0);
    rst_n = 1'b1;
    wait_clk(bp * 2);

    // R1 R2 sweep over lengths, parity modes and values
    for (int l = 0; l < 4; l++) begin
      for (int pm = 0; pm < 3; pm++) begin
        char_len = 2'(l); parity_en = (pm != 0); parity_odd = (pm == 2);
        nlen = l + 5;
        for (int v = 0; v < 6; v++) begin
          m = vals[v] & 8'((1 << nlen) - 1);
          send(vals[v], nlen, parity_en, parity_odd, 0, 1, -1);
          expect_char(m, 0, 0, 0, "R1 R2 sweep");
        end
      end
    end

    // R2 wrong parity detected, even and odd
    char_len = 2'd3; parity_en = 1; parity_odd = 0;
    send(8'h5B, 8, 1, 0, 1, 1, -1);
    expect_char(8'h5B, 1, 0, 0, "R2 even mismatch");
    parity_odd = 1;
    send(8'h07, 8, 1, 1, 1, 1, -1);
    expect_char(8'h07, 1, 0, 0, "R2 odd mismatch");

    // R3 single-sample glitch at bit centre is outvoted
    parity_en = 0;
    send(8'hC6, 8, 0, 0, 0, 1, 2);
    expect_char(8'hC6, 0, 0, 0, "R3 glitch bit2");
    send(8'h39, 8, 0, 0, 0, 1, 5);
    expect_char(8'h39, 0, 0, 0, "R3 glitch bit5");

    // R4 false start: short low pulse
    @(negedge clk); rxd = 1'b0; wait_clk(8); rxd = 1'b1;
    wait_clk(bp * 12);
    chk(data_ready === 1'b0, "R4 false start no char", data_ready, 0);
    send(8'hE4, 8, 0, 0, 0, 1, -1);
    expect_char(8'hE4, 0, 0, 0, "R4 recovery");

    // R5 framing error and resync
    send(8'h96, 8, 0, 0, 0, 0, -1);
    expect_char(8'h96, 0, 1, 0, "R5 framing");
    send(8'h2D, 8, 0, 0, 0, 1, -1);
    expect_char(8'h2D, 0, 0, 0, "R5 resync");

    // R6 break with odd parity: all zero frame
    char_len = 2'd3; parity_en = 1; parity_odd = 1;
    @(negedge clk); rxd = 1'b0; wait_clk(bp * 13); rxd = 1'b1; wait_clk(bp * 2);
    expect_char(8'h00, 1, 1, 1, "R6 break");
    parity_en = 0;
    send(8'h11, 8, 0, 0, 0, 1, -1);
    expect_char(8'h11, 0, 0, 0, "R6 after break");

    // R8 overrun keeps first character
    send(8'hA1, 8, 0, 0, 0, 1, -1);
    send(8'h5E, 8, 0, 0, 0, 1, -1);
    chk(err_overrun === 1'b1, "R8 overrun set", err_overrun, 1);
    chk(rx_data === 8'hA1, "R8 old data kept", rx_data, 8'hA1);
    chk(data_ready === 1'b1, "R8 still ready", data_ready, 1);
    do_read();
    chk(err_overrun === 1'b0, "R8 overrun cleared", err_overrun, 0);
    chk(data_ready === 1'b0, "R7 read clears", data_ready, 0);

    // R9 other divisors
    divisor = 16'd1; bp = 16; wait_clk(bp * 2);
    send(8'h5A, 8, 0, 0, 0, 1, -1);
    expect_char(8'h5A, 0, 0, 0, "R9 divisor 1");
    divisor = 16'd0; wait_clk(bp * 2);
    send(8'hC3, 8, 0, 0, 0, 1, -1);
    expect_char(8'hC3, 0, 0, 0, "R9 divisor 0");
    divisor = 16'd3; bp = 48; wait_clk(bp * 2);
    char_len = 2'd1; parity_en = 1; parity_odd = 0;
    send(8'h2B, 6, 1, 0, 0, 1, -1);
    expect_char(8'h2B, 0, 0, 0, "R9 divisor 3");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule